// File: doc/BRIEF.md
# Programmable Burst Column Address Generator

This block produces the column address sequence for one memory burst. A mode word, written through a load strobe, sets four things: the burst length, the wrap order (linear or XOR), the read latency and a switch that shortens write bursts to one beat. Each start strobe carries a starting column and a read/write flag. From the next cycle on, the block presents one column per clock until the burst runs out or a stop strobe ends it.

Linear order counts upward and wraps inside the aligned block whose size is the burst length. XOR order combines the low bits of the starting column with the beat index. The longest setting covers the whole 256-column row and wraps modulo 256. The block marks the final beat and flags illegal mode settings. The column is formed combinationally from a registered base, a beat counter and a length mask, so a fresh column is available every cycle.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, col_valid_o, last_o and mode_err_o are 0, cas_lat_o is 0, and the active mode is length 1, linear order.
- R2: On a clock edge where mode_load_i is 1, mode_word_i is latched. Bits [2:0] set the length: 000=1, 001=2, 010=4, 011=8, 111=256. Bit 3 sets the order: 0 is linear, 1 is XOR. Bits [6:4] = 001, 010 or 011 give cas_lat_o = 1, 2 or 3; every other value gives cas_lat_o = 0.
- R3: A start_i sampled high makes col_valid_o high from the next cycle, with col_o = start_col_i on that first beat. One beat follows per cycle for the burst length.
- R4: In linear order, beat i shows the start column's low bits plus i, taken modulo the length, and the upper bits stay unchanged. For length 4 and start 2 the order is 2,3,0,1.
- R5: In XOR order, beat i shows the start column's low bits XOR i, and the upper bits stay unchanged. For length 8 and start 5 the order is 5,4,7,6,1,0,3,2.
- R6: Length code 111 with linear order gives 256 beats that wrap modulo 256.
- R7: last_o is 1 exactly on the final beat. col_valid_o is 0 in the following cycle unless a new start was sampled.
- R8: With mode bit 9 set, a start with start_wr_i=1 gives a single beat with last_o=1. A start with start_wr_i=0 keeps the programmed length.
- R9: A stop_i sampled during a burst, without a start, makes col_valid_o 0 from the next cycle. A stop_i while idle has no effect.
- R10: A start sampled during a burst restarts from the new column on the next cycle, with the full length.
- R11: A length code of 100, 101 or 110, or length 111 combined with XOR order, sets mode_err_o to 1 until the next mode load, and every burst then has length 1.
- R12: When start_i and stop_i are sampled together, the start takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_load_i | input | 1 | Latch mode_word_i |
| mode_word_i | input | 12 | Mode word |
| start_i | input | 1 | Begin a burst |
| start_col_i | input | 8 | Starting column |
| start_wr_i | input | 1 | 1 = write burst, 0 = read burst |
| stop_i | input | 1 | Terminate the current burst |
| col_o | output | 8 | Current column |
| col_valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Final beat of the burst |
| mode_err_o | output | 1 | Illegal mode programmed |
| cas_lat_o | output | 2 | Decoded read latency, 0 if reserved |

## Verification
The assertions assume that a mode load happens only while no burst is active, because a burst in flight keeps the length it captured at its start. The properties that tie the single-beat write rule to the mode also assume that the mode does not change in the same cycle as a start. In the stimulus, every mode load comes after the previous burst has ended and its idle cycle has been observed, and every start is issued on a cycle separate from any load. Stop and restart strobes are placed at chosen beats of a running burst, and also while the block is idle.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int unsigned BL_LSB     = 0;
  localparam int unsigned ORDER_BIT  = 3;
  localparam int unsigned CAS_LSB    = 4;
  localparam int unsigned WR_ONE_BIT = 9;

  typedef enum logic [2:0] {
    BL_1    = 3'd0,
    BL_2    = 3'd1,
    BL_4    = 3'd2,
    BL_8    = 3'd3,
    BL_PAGE = 3'd4
  } bl_sel_e;

  typedef struct packed {
    logic       wr_single;
    logic [1:0] cas;
    logic       xor_order;
    bl_sel_e    bl;
    logic       err;
  } mode_cfg_t;
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_col_pkg::*;
#(
  parameter int unsigned MODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] word_i,
  output mode_cfg_t         cfg_o
);
  mode_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d           = '0;
    cfg_d.wr_single = word_i[WR_ONE_BIT];
    cfg_d.xor_order = word_i[ORDER_BIT];
    case (word_i[CAS_LSB +: 3])
      3'b001:  cfg_d.cas = 2'd1;
      3'b010:  cfg_d.cas = 2'd2;
      3'b011:  cfg_d.cas = 2'd3;
      default: cfg_d.cas = 2'd0;
    endcase
    case (word_i[BL_LSB +: 3])
      3'b000: cfg_d.bl = BL_1;
      3'b001: cfg_d.bl = BL_2;
      3'b010: cfg_d.bl = BL_4;
      3'b011: cfg_d.bl = BL_8;
      3'b111: begin
        // whole-row wrap is defined only for linear order
        cfg_d.bl  = word_i[ORDER_BIT] ? BL_1 : BL_PAGE;
        cfg_d.err = word_i[ORDER_BIT];
      end
      default: begin
        cfg_d.bl  = BL_1;
        cfg_d.err = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  assert_err_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cfg_q));
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_cfg_t        cfg_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             start_wr_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             xor_o
);
  logic             active_q;
  logic [COL_W-1:0] beat_q, base_q, mask_q;
  logic             xor_q;
  logic [COL_W-1:0] start_mask;
  logic             last;

  function automatic logic [COL_W-1:0] bl_mask(bl_sel_e b);
    case (b)
      BL_1:    return '0;
      BL_2:    return COL_W'(1);
      BL_4:    return COL_W'(3);
      BL_8:    return COL_W'(7);
      default: return '1;
    endcase
  endfunction

  always_comb begin
    if (cfg_i.err || (start_wr_i && cfg_i.wr_single)) start_mask = '0;
    else                                               start_mask = bl_mask(cfg_i.bl);
  end

  assign last = active_q && (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      xor_q    <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      base_q   <= start_col_i;
      mask_q   <= start_mask;
      xor_q    <= cfg_i.xor_order;
    end else if (active_q) begin
      if (stop_i || last) active_q <= 1'b0;
      else                beat_q   <= beat_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign last_o   = last;
  assign base_o   = base_q;
  assign beat_o   = beat_q;
  assign mask_o   = mask_q;
  assign xor_o    = xor_q;

  assert_beat_in_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> ((beat_q & ~mask_q) == '0));
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             xor_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + beat_i;

  // bits above the mask keep the start column; carries past the mask are dropped
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? (xor_i ? (base_i[i] ^ beat_i[i]) : sum[i])
                                : base_i[i];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W  = 8,
  parameter int unsigned MODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_load_i,
  input  logic [MODE_W-1:0] mode_word_i,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              start_wr_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              col_valid_o,
  output logic              last_o,
  output logic              mode_err_o,
  output logic [1:0]        cas_lat_o
);
  mode_cfg_t        cfg;
  logic [COL_W-1:0] base, beat, mask;
  logic             use_xor;

  burst_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(mode_load_i),
    .word_i(mode_word_i),
    .cfg_o (cfg)
  );

  burst_seq #(.COL_W(COL_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .start_i    (start_i),
    .start_col_i(start_col_i),
    .start_wr_i (start_wr_i),
    .stop_i     (stop_i),
    .active_o   (col_valid_o),
    .last_o     (last_o),
    .base_o     (base),
    .beat_o     (beat),
    .mask_o     (mask),
    .xor_o      (use_xor)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_i(base),
    .beat_i(beat),
    .mask_i(mask),
    .xor_i (use_xor),
    .col_o (col_o)
  );

  assign mode_err_o = cfg.err;
  assign cas_lat_o  = cfg.cas;

  assert_first_col_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (col_valid_o && col_o == $past(start_col_i)));
  assert_no_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_valid_o && !last_o && !stop_i) |=> col_valid_o);
  assert_end_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !col_valid_o);
  assert_stop_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !col_valid_o);
  assert_single_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && start_wr_i && cfg.wr_single && !mode_load_i) |=> last_o);
  assert_err_len1_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_err_o && !mode_load_i) |=> last_o);
endmodule

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_load = 1'b0;
  logic [11:0] mode_word = '0;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic       start_wr = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] col;
  logic       col_valid, last, mode_err;
  logic [1:0] cas_lat;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  burst_col_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_load_i(mode_load), .mode_word_i(mode_word),
    .start_i(start), .start_col_i(start_col), .start_wr_i(start_wr), .stop_i(stop),
    .col_o(col), .col_valid_o(col_valid), .last_o(last), .mode_err_o(mode_err),
    .cas_lat_o(cas_lat)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(int base, int i, int len, bit use_xor);
    int m = len - 1;
    if (use_xor) return ((base & ~m) | ((base ^ i) & m)) & 255;
    return ((base & ~m) | ((base + i) & m)) & 255;
  endfunction

  task automatic load_mode(logic [11:0] w);
    @(negedge clk); mode_load = 1'b1; mode_word = w;
    @(negedge clk); mode_load = 1'b0;
  endtask

  // after return: outputs show beat 0
  task automatic start_burst(int c, bit wr);
    @(negedge clk); start = 1'b1; start_col = c[7:0]; start_wr = wr;
    @(negedge clk); start = 1'b0; start_wr = 1'b0;
  endtask

  task automatic run_burst(string tag, int c, bit wr, int len, bit use_xor);
    start_burst(c, wr);
    for (int i = 0; i < len; i++) begin
      chk({tag, " valid"}, col_valid, 1);
      chk({tag, " col"}, col, exp_col(c, i, len, use_xor));
      chk({tag, " last"}, last, (i == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk({tag, " idle after last R7"}, col_valid, 0);
  endtask

  task automatic run_list(string tag, int c, int len, int exp[8]);
    start_burst(c, 1'b0);
    for (int i = 0; i < len; i++) begin
      chk({tag, " col"}, col, exp[i]);
      @(negedge clk);
    end
    chk({tag, " idle"}, col_valid, 0);
  endtask

  task automatic t_reset();
    chk("R1 valid", col_valid, 0);
    chk("R1 last", last, 0);
    chk("R1 err", mode_err, 0);
    chk("R1 cas", cas_lat, 0);
    run_burst("R1 default len1", 8'h37, 1'b0, 1, 1'b0);
  endtask

  task automatic t_seq();
    int e4[8] = '{2, 3, 0, 1, 0, 0, 0, 0};
    int e8[8] = '{6, 7, 0, 1, 2, 3, 4, 5};
    load_mode(12'h022);
    chk("R2 cas2", cas_lat, 2);
    chk("R2 err", mode_err, 0);
    run_list("R4 len4 start2", 2, 4, e4);
    run_burst("R4 len4 upper bits", 8'h12, 1'b0, 4, 1'b0);
    load_mode(12'h013);
    chk("R2 cas1", cas_lat, 1);
    run_list("R4 len8 start6", 6, 8, e8);
    load_mode(12'h011);
    run_burst("R4 len2", 8'h33, 1'b1, 2, 1'b0);
  endtask

  task automatic t_xor();
    int e8[8] = '{8'h45, 8'h44, 8'h47, 8'h46, 8'h41, 8'h40, 8'h43, 8'h42};
    load_mode(12'h03B);
    chk("R2 cas3", cas_lat, 3);
    run_list("R5 len8 start5", 8'h45, 8, e8);
    load_mode(12'h02A);
    run_burst("R5 len4", 8'h9E, 1'b0, 4, 1'b1);
  endtask

  task automatic t_page();
    load_mode(12'h037);
    chk("R6 err", mode_err, 0);
    run_burst("R6 page", 8'hFE, 1'b0, 256, 1'b0);
  endtask

  task automatic t_wr_single();
    load_mode(12'h222);
    run_burst("R8 write single", 8'h21, 1'b1, 1, 1'b0);
    run_burst("R8 read keeps len", 8'h21, 1'b0, 4, 1'b0);
  endtask

  task automatic t_stop();
    load_mode(12'h013);
    start_burst(8'h50, 1'b0);
    chk("R9 beat0", col, 8'h50);
    @(negedge clk);
    chk("R9 beat1", col, 8'h51);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R9 stopped", col_valid, 0);
    chk("R9 no last", last, 0);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    chk("R9 idle stop valid", col_valid, 0);
    run_burst("R9 after idle stop", 8'h50, 1'b0, 8, 1'b0);
  endtask

  task automatic t_restart(bit with_stop);
    string tag = with_stop ? "R12" : "R10";
    load_mode(12'h022);
    start_burst(8'h20, 1'b0);
    chk({tag, " first"}, col, 8'h20);
    @(negedge clk);
    chk({tag, " second"}, col, 8'h21);
    start = 1'b1; start_col = 8'h81; stop = with_stop;
    @(negedge clk); start = 1'b0; stop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk({tag, " valid"}, col_valid, 1);
      chk({tag, " col"}, col, exp_col(8'h81, i, 4, 1'b0));
      chk({tag, " last"}, last, (i == 3) ? 1 : 0);
      @(negedge clk);
    end
    chk({tag, " idle"}, col_valid, 0);
  endtask

  task automatic t_reserved();
    load_mode(12'h024);
    chk("R11 code100 err", mode_err, 1);
    chk("R2 cas with bad len", cas_lat, 2);
    run_burst("R11 code100 len1", 8'h47, 1'b0, 1, 1'b0);
    load_mode(12'h006);
    chk("R11 code110 err", mode_err, 1);
    load_mode(12'h03F);
    chk("R11 page xor err", mode_err, 1);
    run_burst("R11 page xor len1", 8'h10, 1'b0, 1, 1'b0);
    load_mode(12'h042);
    chk("R11 err cleared", mode_err, 0);
    chk("R2 reserved cas", cas_lat, 0);
    run_burst("R2 len4 after reserved cas", 8'h05, 1'b0, 4, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seq();
    t_xor();
    t_page();
    t_wr_single();
    t_stop();
    t_restart(1'b0);
    t_restart(1'b1);
    t_reserved();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule